// File: doc/BRIEF.md
# Three-Operand Adder with Carry-Generate

This unit adds three 64-bit register values in a single operation and hands back one of two results, chosen by a small opcode. The sum opcode returns the low 64 bits of A + B + C. The carry opcode runs the same three-input addition and returns only the carry out of bit 63, zero-extended into an ordinary 64-bit result. The datapath never grows past 64 bits, and there is no flags register. Carry information moves between operations as a normal register value.

Software builds wide additions by pairing the two opcodes over each 64-bit limb. The carry result of one pair becomes the C operand of the next pair, and the first pair uses zero. Four such pairs make a 256-bit addition with a 257th bit at the end. When C is an arbitrary register value, the carry out can reach two, so the carry opcode returns a 2-bit count. The unit has one cycle of latency. Both the result and a valid strobe are registered. Any opcode the unit does not define produces a zero result and raises an illegal flag for that output cycle.

Top module: `tri_add_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: `out_valid` in a cycle equals `in_valid` sampled at the previous rising clock edge (one-cycle latency).
- R3: With `in_op` = 2'b00 (sum), `out_result` one cycle later equals bits [63:0] of A + B + C.
- R4: With `in_op` = 2'b01 (carry), `out_result` one cycle later holds the carry count of A + B + C (the bits above bit 63, value 0, 1 or 2) in bits [1:0], and bits [63:2] are zero.
- R5: With C = 0, the sum opcode returns the plain two-operand sum A + B modulo 2^64, and the carry opcode returns 0 or 1.
- R6: With `in_op` = 2'b10 or 2'b11, `out_result` is zero and `out_illegal` is high in the output cycle, and `out_illegal` is low for a legal opcode.
- R7: When `in_valid` is low, the next cycle shows `out_result` = 0 and `out_illegal` = 0 whatever the opcode and operands.
- R8: Four sum/carry pairs chained limb by limb, each pair taking the previous carry result as C and the first taking zero, give the same 257-bit value as a direct 256-bit addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 2 | Opcode: 00 sum, 01 carry, 10/11 undefined |
| in_a | input | 64 | First addend |
| in_b | input | 64 | Second addend |
| in_c | input | 64 | Third addend (a full register value) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | Undefined opcode seen on the previous valid request |

## Verification
Every result, including the valid strobe and the illegal flag, is due on the rising edge that follows the edge at which the request is captured. The bench changes inputs on the falling edge and reads outputs one time unit after the next rising edge, so each check looks at exactly the cycle that belongs to its request. The chained 256-bit tests issue one request per cycle. Each carry result is read in its due cycle and driven back as C on the following falling edge, and the assembled limbs and the final carry are then compared against a 257-bit sum computed in the bench.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
  localparam int OPCODE_W = 2;

  typedef enum logic [OPCODE_W-1:0] {
    OP_SUM   = 2'd0,
    OP_CARRY = 2'd1,
    OP_RSV2  = 2'd2,
    OP_RSV3  = 2'd3
  } op_e;
endpackage

// File: rtl/tri_add_csa.sv
// 3:2 carry-save compressor: reduces three addends to a sum vector and
// a carry vector, one full-adder cell per bit with no carry propagation.
module tri_add_csa #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum_bits,
  output logic [W-1:0] carry_bits
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum_bits[i]   = a[i] ^ b[i] ^ c[i];
    assign carry_bits[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end
endmodule

// File: rtl/tri_add_cpa.sv
// Carry-propagate stage: adds the sum vector and the carry vector shifted
// left by one, producing W+2 bits so the 2-bit carry count is kept.
module tri_add_cpa #(
  parameter int W      = 64,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [W-1:0] sum_bits,
  input  logic [W-1:0] carry_bits,
  output logic [W+1:0] total
);
  localparam int TW = W + 2;

  logic [TW-1:0] x;
  logic [TW-1:0] y;

  assign x = {2'b00, sum_bits};
  assign y = {1'b0, carry_bits, 1'b0};

  if (RIPPLE) begin : g_ripple
    logic [TW-1:0] chain;
    assign chain[0] = 1'b0;
    for (genvar i = 0; i < TW; i++) begin : g_bit
      assign total[i] = x[i] ^ y[i] ^ chain[i];
      if (i < TW - 1) begin : g_link
        assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
      end
    end
  end else begin : g_infer
    assign total = x + y;
  end
endmodule

// File: rtl/tri_add_select.sv
// Opcode select: low word for the sum opcode, zero-extended carry count
// for the carry opcode, zero plus an illegal flag otherwise.
module tri_add_select
  import tri_add_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [OPCODE_W-1:0] op,
  input  logic [W+1:0]        total,
  output logic [W-1:0]        result,
  output logic                illegal
);
  localparam int PAD_W = W - 2;

  always_comb begin
    result  = '0;
    illegal = 1'b0;
    case (op_e'(op))
      OP_SUM:   result = total[W-1:0];
      OP_CARRY: result = {{PAD_W{1'b0}}, total[W+1:W]};
      default:  illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/tri_add_unit.sv
// Three-operand adder with carry-generate opcode, one-cycle latency.
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit RIPPLE_CPA = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [OPCODE_W-1:0] in_op,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic [DATA_W-1:0]   in_c,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_result,
  output logic                out_illegal
);
  logic [DATA_W-1:0] csa_sum;
  logic [DATA_W-1:0] csa_carry;
  logic [DATA_W+1:0] full_total;
  logic [DATA_W-1:0] sel_result;
  logic              sel_illegal;

  tri_add_csa #(.W(DATA_W)) u_csa (
    .a          (in_a),
    .b          (in_b),
    .c          (in_c),
    .sum_bits   (csa_sum),
    .carry_bits (csa_carry)
  );

  tri_add_cpa #(.W(DATA_W), .RIPPLE(RIPPLE_CPA)) u_cpa (
    .sum_bits   (csa_sum),
    .carry_bits (csa_carry),
    .total      (full_total)
  );

  tri_add_select #(.W(DATA_W)) u_sel (
    .op      (in_op),
    .total   (full_total),
    .result  (sel_result),
    .illegal (sel_illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_result  <= in_valid ? sel_result : '0;
      out_illegal <= in_valid & sel_illegal;
    end
  end
endmodule

// File: rtl/tri_add_checker.sv
module tri_add_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] in_c,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_illegal
);
  logic [W+1:0] ref_total;
  assign ref_total = {2'b00, in_a} + {2'b00, in_b} + {2'b00, in_c};

  // R2
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  p_sum_low_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b00) |=> (out_result == $past(ref_total[W-1:0]) && !out_illegal));

  // R4
  p_carry_count_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b01) |=>
      (out_result == {{(W-2){1'b0}}, $past(ref_total[W+1:W])} && out_result[1:0] != 2'b11));

  // R6
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[1]) |=> (out_illegal && out_result == '0));

  // R7
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (out_result == '0 && !out_illegal));
endmodule

bind tri_add_unit tri_add_checker #(.W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .in_a        (in_a),
  .in_b        (in_b),
  .in_c        (in_c),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/tri_add_unit_tb_top.sv
`timescale 1ns/1ps
module tri_add_unit_tb_top;
  localparam int W = 64;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   in_op = 2'b00;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [W-1:0] in_c = '0;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tri_add_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input logic [W-1:0] act_r, input logic [W-1:0] exp_r,
                       input logic act_v, input logic exp_v, input logic act_i, input logic exp_i);
    checks++;
    if (act_r !== exp_r || act_v !== exp_v || act_i !== exp_i) begin
      failures++;
      $display("FAIL %s: result=%h valid=%b illegal=%b expected result=%h valid=%b illegal=%b",
               req, act_r, act_v, act_i, exp_r, exp_v, exp_i);
    end
  endtask

  // Drive on the falling edge; outputs are read 1 ns after the next rising edge.
  task automatic issue(input logic v, input logic [1:0] op,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    @(negedge clk);
    in_valid = v; in_op = op; in_a = a; in_b = b; in_c = c;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W+1:0] ref3(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    return {2'b00, a} + {2'b00, b} + {2'b00, c};
  endfunction

  task automatic t_reset();
    check("R1 during reset", out_result, '0, out_valid, 1'b0, out_illegal, 1'b0);
    @(negedge clk); rst = 1'b0;
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 after release", out_result, '0, out_valid, 1'b0, out_illegal, 1'b0);
  endtask

  task automatic t_sum(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W+1:0] t;
    t = ref3(a, b, c);
    issue(1'b1, 2'b00, a, b, c);
    check("R3 sum", out_result, t[W-1:0], out_valid, 1'b1, out_illegal, 1'b0);
  endtask

  task automatic t_carry(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                         input logic [1:0] exp_cnt);
    issue(1'b1, 2'b01, a, b, c);
    check("R4 carry count", out_result, {{(W-2){1'b0}}, exp_cnt}, out_valid, 1'b1, out_illegal, 1'b0);
  endtask

  task automatic t_two_operand();
    logic [W-1:0] a;
    logic [W-1:0] b;
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    issue(1'b1, 2'b00, a, b, '0);
    check("R5 two-operand sum", out_result, a + b, out_valid, 1'b1, out_illegal, 1'b0);
    issue(1'b1, 2'b01, ONES, 64'd1, '0);
    check("R5 two-operand carry", out_result, 64'd1, out_valid, 1'b1, out_illegal, 1'b0);
  endtask

  task automatic t_illegal();
    issue(1'b1, 2'b10, ONES, ONES, ONES);
    check("R6 op 10", out_result, '0, out_valid, 1'b1, out_illegal, 1'b1);
    issue(1'b1, 2'b11, 64'd5, 64'd7, 64'd9);
    check("R6 op 11", out_result, '0, out_valid, 1'b1, out_illegal, 1'b1);
    issue(1'b1, 2'b00, 64'd5, 64'd7, 64'd9);
    check("R6 legal clears flag", out_result, 64'd21, out_valid, 1'b1, out_illegal, 1'b0);
  endtask

  task automatic t_idle();
    issue(1'b0, 2'b00, 64'd3, 64'd4, 64'd5);
    check("R7 idle sum", out_result, '0, out_valid, 1'b0, out_illegal, 1'b0);
    issue(1'b0, 2'b11, ONES, ONES, ONES);
    check("R7 idle illegal op", out_result, '0, out_valid, 1'b0, out_illegal, 1'b0);
    issue(1'b1, 2'b01, ONES, ONES, ONES);
    check("R2 valid returns", out_result, 64'd2, out_valid, 1'b1, out_illegal, 1'b0);
  endtask

  task automatic t_chain(input logic [255:0] a, input logic [255:0] b);
    logic [256:0] expv;
    logic [256:0] got;
    logic [W-1:0] carry;
    carry = '0;
    got = '0;
    expv = {1'b0, a} + {1'b0, b};
    for (int i = 0; i < 4; i++) begin
      issue(1'b1, 2'b00, a[i*W +: W], b[i*W +: W], carry);
      got[i*W +: W] = out_result;
      issue(1'b1, 2'b01, a[i*W +: W], b[i*W +: W], carry);
      carry = out_result;
    end
    got[256] = carry[0];
    checks++;
    if (got !== expv || carry[W-1:1] !== '0) begin
      failures++;
      $display("FAIL R8 chained 256-bit add: got=%h carryword=%h expected=%h", got, carry, expv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_sum(64'd1, 64'd2, 64'd3);
    t_sum(ONES, ONES, ONES);
    t_sum({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    t_carry(64'd1, 64'd2, 64'd3, 2'd0);
    t_carry(ONES, 64'd1, 64'd0, 2'd1);
    t_carry(ONES, ONES, ONES, 2'd2);
    t_carry(ONES, ONES, 64'd2, 2'd2);
    t_two_operand();
    t_illegal();
    t_idle();
    t_chain({256{1'b1}}, {256{1'b1}});
    t_chain({256{1'b1}}, 256'd1);
    t_chain(256'd0, 256'd0);
    for (int k = 0; k < 6; k++) begin
      t_chain({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule